// File: doc/BRIEF.md
# Presettable Johnson Divide-by-N Counter

This block divides its clock by any integer from 2 to 10. The core is a five-stage twisted-ring shift register. A small decoder turns a 4-bit select into a ratio. A feedback network then picks which stage, or which pair of adjacent stages, drives the serial input of the first stage.

Even ratios use an inverted single tap. Odd ratios use a NAND of two adjacent taps, which drops the all-zero state from the loop. No outside gate is needed for either.

The divided output is the highest stage in use. Every stage is also visible on its own output. An active-high reset clears the ring, and an active-high preset loads five jam bits. Both act asynchronously. A correction path watches the stages in use and forces the ring back into a legal pattern if it ever holds a code that cannot occur in the count.

Top module: `johnson_divider`

## Requirements
- R1: While `rst` is high, all five bits of `stage_q` are 0 and `div_out` is 0, at once and without a clock edge. Reset wins over `preset_en`.
- R2: On each rising clock edge with `rst` and `preset_en` low and the ring legal, `stage_q[i]` takes the old `stage_q[i-1]` for i = 1..4, and `stage_q[0]` takes the feedback bit.
- R3: While `preset_en` is high and `rst` is low, `stage_q[i]` equals `jam[i]` for every i. This holds at once and across clock edges.
- R4: A `div_sel` value of 2 to 10 selects that ratio. Any other value (0, 1, 11 to 15) behaves exactly as ratio 10.
- R5: For an even ratio 2m, the m stages `stage_q[m-1:0]` are in use. The feedback bit is NOT `stage_q[m-1]`, and `div_out` is `stage_q[m-1]`. The output has period 2m clocks and is high for m of them.
- R6: For an odd ratio 2k+1 (k = 1..4), the k+1 stages `stage_q[k:0]` are in use. The feedback bit is NAND(`stage_q[k]`, `stage_q[k-1]`), and `div_out` is `stage_q[k]`. The output has period 2k+1 clocks and is high for k+1 of them.
- R7: The stages in use form a legal code when at most one adjacent pair among them differs. If they do not, the next rising clock edge clears all five stages. From any jammed state, the output reaches its steady period within ratio+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock; the ring shifts on the rising edge |
| rst | input | 1 | Asynchronous active-high clear of all stages |
| preset_en | input | 1 | Asynchronous active-high load of `jam` into the stages |
| jam | input | 5 | Preset value; bit i goes to stage i |
| div_sel | input | 4 | Ratio select, 2 to 10; other values act as 10 |
| stage_q | output | 5 | Buffered stage outputs; bit 0 is the first stage |
| div_out | output | 1 | Divided clock: the highest stage in use |

## Verification
The stage outputs show the ring directly, so a corrupted bit appears on `stage_q` in the very cycle it is stored. It also propagates one stage per clock toward `div_out`. A wrong tap or a wrong gate in the feedback path changes the period or the high time of `div_out`, and this shows within one output period. An illegal code that is not corrected shows as a period other than the selected ratio. A stuck pattern would leave `div_out` with no rising edge at all, and a check bounded by ratio+1 clocks catches both cases.

// File: rtl/jd_pkg.sv
package jd_pkg;

  // Ratio actually used for a select value; out-of-range values fall back to the largest ratio.
  function automatic int ratio_of_sel(input int sel_val, input int stages);
    if (sel_val < 2 || sel_val > 2 * stages) return 2 * stages;
    return sel_val;
  endfunction

  // Number of ring stages that take part in a given ratio.
  function automatic int taps_of_ratio(input int ratio);
    return (ratio + 1) / 2;
  endfunction

  // Number of adjacent bit pairs that differ within the low `width` bits.
  function automatic int edge_count(input logic [31:0] pat, input int width);
    int n;
    n = 0;
    for (int i = 0; i < 31; i++) begin
      if ((i + 1) < width && pat[i] != pat[i+1]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/jd_ratio_dec.sv
module jd_ratio_dec #(
  parameter int STAGES = 5,
  parameter int SEL_W  = 4,
  parameter int IDX_W  = $clog2(STAGES)
) (
  input  logic [SEL_W-1:0] div_sel,
  output logic [IDX_W-1:0] top_idx,
  output logic             odd_mode
);
  import jd_pkg::*;

  int ratio_v;

  always_comb begin
    ratio_v  = ratio_of_sel(int'(div_sel), STAGES);
    top_idx  = IDX_W'(taps_of_ratio(ratio_v) - 1);
    odd_mode = ratio_v[0];
  end

endmodule

// File: rtl/jd_feedback.sv
module jd_feedback #(
  parameter int STAGES = 5,
  parameter int IDX_W  = $clog2(STAGES)
) (
  input  logic [STAGES-1:0] ring_q,
  input  logic [IDX_W-1:0]  top_idx,
  input  logic              odd_mode,
  output logic              tap_hi,
  output logic              tap_lo,
  output logic              fb_bit,
  output logic              ring_bad
);
  import jd_pkg::*;

  localparam int PAD = 32 - STAGES;

  logic [IDX_W-1:0] lo_idx;
  logic [31:0]      ring_wide;

  assign lo_idx    = (top_idx == '0) ? '0 : top_idx - IDX_W'(1);
  assign tap_hi    = ring_q[top_idx];
  assign tap_lo    = ring_q[lo_idx];
  assign ring_wide = {{PAD{1'b0}}, ring_q};

  // Even ratios invert one tap; odd ratios gate two neighbours so one state drops out.
  assign fb_bit   = odd_mode ? ~(tap_hi & tap_lo) : ~tap_hi;
  assign ring_bad = edge_count(ring_wide, int'(top_idx) + 1) > 1;

endmodule

// File: rtl/jd_ring.sv
module jd_ring #(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              preset_en,
  input  logic [STAGES-1:0] jam,
  input  logic              fb_bit,
  input  logic              clear,
  output logic [STAGES-1:0] ring_q
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic st_q;
    logic st_d;
    if (i == 0) begin : g_head
      assign st_d = clear ? 1'b0 : fb_bit;
    end else begin : g_body
      assign st_d = clear ? 1'b0 : ring_q[i-1];
    end
    always_ff @(posedge clk or posedge rst or posedge preset_en) begin
      if (rst)            st_q <= 1'b0;
      else if (preset_en) st_q <= jam[i];
      else                st_q <= st_d;
    end
    assign ring_q[i] = st_q;
  end

  // R1: reset forces an all-zero ring, whatever preset does
  p_reset_clear_r1: assert property (@(posedge clk) rst |-> ring_q == '0);

  // R3: preset holds the jam value on the stages across edges
  p_preset_load_r3: assert property (@(posedge clk) disable iff (rst)
    preset_en |-> ring_q == jam);

  // R2: in a legal state the ring moves one place per edge
  p_shift_r2: assert property (@(posedge clk) disable iff (rst || preset_en)
    !clear |=> ring_q[STAGES-1:1] == $past(ring_q[STAGES-2:0]));

  // R7: an illegal code is wiped on the next edge
  p_antilock_r7: assert property (@(posedge clk) disable iff (rst || preset_en)
    clear |=> ring_q == '0);

endmodule

// File: rtl/johnson_divider.sv
module johnson_divider #(
  parameter int STAGES = 5,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              preset_en,
  input  logic [4:0]        jam,
  input  logic [3:0]        div_sel,
  output logic [4:0]        stage_q,
  output logic              div_out
);
  localparam int IDX_W = $clog2(STAGES);

  logic [IDX_W-1:0]  top_idx;
  logic              odd_mode;
  logic              tap_hi;
  logic              tap_lo;
  logic              fb_bit;
  logic              ring_bad;
  logic [STAGES-1:0] ring_q;

  jd_ratio_dec #(.STAGES(STAGES), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_dec (
    .div_sel  (div_sel),
    .top_idx  (top_idx),
    .odd_mode (odd_mode)
  );

  jd_feedback #(.STAGES(STAGES), .IDX_W(IDX_W)) u_fb (
    .ring_q   (ring_q),
    .top_idx  (top_idx),
    .odd_mode (odd_mode),
    .tap_hi   (tap_hi),
    .tap_lo   (tap_lo),
    .fb_bit   (fb_bit),
    .ring_bad (ring_bad)
  );

  jd_ring #(.STAGES(STAGES)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .preset_en (preset_en),
    .jam       (jam),
    .fb_bit    (fb_bit),
    .clear     (ring_bad),
    .ring_q    (ring_q)
  );

  assign stage_q = ring_q;
  assign div_out = tap_hi;

  // R5: even ratios feed back the inverse of the output stage
  p_feedback_even_r5: assert property (@(posedge clk) disable iff (rst || preset_en)
    (!ring_bad && !odd_mode) |=> ring_q[0] == !$past(div_out));

  // R6: odd ratios feed back the NAND of the top two stages in use
  p_feedback_odd_r6: assert property (@(posedge clk) disable iff (rst || preset_en)
    (!ring_bad && odd_mode) |=> ring_q[0] == !($past(tap_hi) && $past(tap_lo)));

  // R4: an out-of-range select taps the last stage
  p_default_ratio_r4: assert property (@(posedge clk) disable iff (rst)
    (int'(div_sel) < 2 || int'(div_sel) > 2 * STAGES) |-> div_out == ring_q[STAGES-1]);

endmodule

// File: tb/sim_johnson_divider.sv
module sim_johnson_divider;
  logic       clk = 1'b0;
  logic       rst;
  logic       preset_en;
  logic [4:0] jam;
  logic [3:0] div_sel;
  wire  [4:0] stage_q;
  wire        div_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  johnson_divider u0 (
    .clk(clk), .rst(rst), .preset_en(preset_en), .jam(jam),
    .div_sel(div_sel), .stage_q(stage_q), .div_out(div_out)
  );

  function automatic int b_ratio(input int s);
    return (s >= 2 && s <= 10) ? s : 10;
  endfunction

  function automatic int b_width(input int r);
    return r / 2 + r % 2;
  endfunction

  // Legal codes listed as ones-then-zeros or zeros-then-ones over the low n bits.
  function automatic bit b_code_ok(input int pat, input int n);
    int mask;
    mask = (1 << n) - 1;
    for (int j = 0; j <= n; j++) begin
      int low;
      low = (1 << j) - 1;
      if ((pat & mask) == low || (pat & mask) == (mask ^ low)) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    rst = 1'b0;
  endtask

  task automatic measure(input int r, input string req);
    int per;
    int hi;
    bit p;
    for (int g = 0; g < 40; g++) begin
      p = div_out;
      tick();
      if (!p && div_out) break;
    end
    per = 0;
    hi = 0;
    do begin
      hi += int'(div_out);
      p = div_out;
      tick();
      per++;
    end while (!(!p && div_out) && per < 40);
    chk(per == r, req, per, r);
    chk(hi == (r + 1) / 2, req, hi, (r + 1) / 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int s;
    int n;
    int r;
    int code;
    int upper;
    int jv;
    int expfb;
    int bad_seen;
    int odd_sel[4];
    void'($urandom(32'd7411));
    odd_sel[0] = 0; odd_sel[1] = 1; odd_sel[2] = 11; odd_sel[3] = 15;
    rst = 1'b1; preset_en = 1'b0; jam = '0; div_sel = 4'd10;
    tick();
    #1;
    // R1: state while reset is held
    chk(stage_q == 5'd0, "R1 reset state", int'(stage_q), 0);
    chk(div_out == 1'b0, "R1 reset output", int'(div_out), 0);
    rst = 1'b0;

    // R5 / R6: every in-range ratio from a cleared ring
    for (int k = 2; k <= 10; k++) begin
      div_sel = 4'(k);
      do_reset();
      measure(k, (k % 2 == 0) ? "R5 even period" : "R6 odd period");
    end

    // R4: out-of-range selects behave as ratio 10
    for (int k = 0; k < 4; k++) begin
      div_sel = 4'(odd_sel[k]);
      do_reset();
      measure(10, "R4 default ratio");
    end

    // R7: every illegal jammed code clears, then the count resumes
    for (int k = 2; k <= 10; k++) begin
      n = b_width(k);
      div_sel = 4'(k);
      bad_seen = 0;
      for (int x = 0; x < 32; x++) begin
        if (!b_code_ok(x, n)) begin
          jam = 5'(x);
          preset_en = 1'b1;
          tick();
          preset_en = 1'b0;
          tick();
          chk(stage_q == 5'd0, "R7 illegal cleared", int'(stage_q), 0);
          if (bad_seen < 3) measure(k, "R7 recovery period");
          bad_seen++;
        end
      end
    end

    // Random mid-count reset and preset
    for (int it = 0; it < 60; it++) begin
      s = (it % 5 == 4) ? int'($urandom_range(11, 15)) : int'($urandom_range(2, 10));
      r = b_ratio(s);
      n = b_width(r);
      div_sel = 4'(s);
      do_reset();
      repeat ($urandom_range(0, 15)) tick();
      if ($urandom_range(0, 1) == 0) begin
        // R1: reset mid-count, with preset also raised
        jam = 5'($urandom_range(1, 31));
        preset_en = 1'b1;
        rst = 1'b1;
        #1;
        chk(stage_q == 5'd0, "R1 mid-count reset", int'(stage_q), 0);
        tick();
        chk(stage_q == 5'd0, "R1 reset over preset", int'(stage_q), 0);
        rst = 1'b0;
        preset_en = 1'b0;
      end else begin
        // R3: legal preset mid-count, then one shift (R2) and feedback (R5/R6)
        jv = int'($urandom_range(0, n));
        code = (1 << jv) - 1;
        if ($urandom_range(0, 1) == 1) code = code ^ ((1 << n) - 1);
        upper = int'($urandom_range(0, 31)) & ~((1 << n) - 1);
        jam = 5'(code | upper);
        preset_en = 1'b1;
        #1;
        chk(stage_q == jam, "R3 async preset", int'(stage_q), int'(jam));
        tick();
        chk(stage_q == jam, "R3 preset held", int'(stage_q), int'(jam));
        preset_en = 1'b0;
        tick();
        chk(stage_q[4:1] == jam[3:0], "R2 shift after preset", int'(stage_q[4:1]), int'(jam[3:0]));
        if (r % 2 == 0) expfb = int'(!jam[n-1]);
        else expfb = int'(!(jam[n-1] && jam[n-2]));
        chk(int'(stage_q[0]) == expfb, (r % 2 == 0) ? "R5 feedback bit" : "R6 feedback bit",
            int'(stage_q[0]), expfb);
      end
      measure(r, (s > 10) ? "R4 random period" : ((r % 2 == 0) ? "R5 random period" : "R6 random period"));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule